// File: doc/BRIEF.md
# Parallel-Window Run-Length Encoder

This block compresses a fixed-width register snapshot into a packed stream of tokens, so that it can be stored in fewer bits. A pulse on `start_i` captures the snapshot together with two settings: the width of the inspection window and a run-length threshold. The block then scans the snapshot from bit 0 upward. Each cycle it looks at a window of adjacent bits. If that window fits inside the snapshot and all its bits are equal, the scan moves past the whole window in one cycle. In every other case it moves forward by a single bit.

Consecutive equal bits are collected into a run. When a run ends, the block emits it in one of two ways. A run longer than the threshold becomes one run token. A shorter run is copied out as literal tokens, one per bit. Tokens are packed from bit 0 of the output word with no gaps between them. When the scan is finished, the block raises `done_o` and reports the total code length.

Top module: `rle_par_enc`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low, `code_len_o` is 0 and `code_o` is all zeros.
- R2: Let k be the effective window width. If bits pos..pos+k-1 lie inside the snapshot and are all equal, the scan position advances by k in one cycle.
- R3: A window that is not uniform advances the position by one bit. So does a window that would reach past bit N-1. No bit at or above N is ever consumed.
- R4: A run whose length L is greater than the threshold is emitted as one run token. Its lowest bit is the flag 1. The next bit is the run value. After that comes L in a field of ceil(log2(N+1)) bits, least significant bit first.
- R5: A run whose length L is at most the threshold is emitted as L literal tokens. Each literal token is the flag 0 followed by the data bit.
- R6: Tokens are placed in scan order, starting at bit 0 of `code_o`, with no gaps. `code_len_o` counts the bits used so far. Every bit at or above `code_len_o` is zero.
- R7: After a start, `busy_o` is high for S+1 cycles, where S is the number of scan steps. After that, `done_o` is high and `code_len_o` holds the final length. These outputs stay unchanged until the next start.
- R8: Decoding `code_o` with the token rules of R4 and R5 gives back the captured snapshot exactly.
- R9: A window setting of 0 is treated as 1. A window setting above KMAX is treated as KMAX.
- R10: Data, window and threshold are captured on the start cycle. Changes to these inputs while busy have no effect on the result.
- R11: A start pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture the inputs and begin compressing |
| data_i | input | N | Snapshot to compress |
| win_i | input | $clog2(KMAX+1) | Window width setting |
| thresh_i | input | $clog2(N+1) | Run-length threshold |
| busy_o | output | 1 | Compression in progress |
| done_o | output | 1 | Result valid |
| code_o | output | N*(2+$clog2(N+1)) | Packed token stream, first token at bit 0 |
| code_len_o | output | $clog2(N*(2+$clog2(N+1))+1) | Number of valid code bits |

## Verification
All-zero and all-one snapshots exercise the one-cycle window skip and the single long-run token. With a window width that does not divide N, they also show that the tail is handled bit by bit. An alternating pattern never forms a uniform window, so it isolates the literal path and the one-bit advance. A snapshot whose only run sits exactly at the threshold, and again one past it, separates literal coding from run-token coding. Random patterns with biased run lengths mix both token kinds. These patterns are combined with several window widths and thresholds, including the clamped window settings, input changes during a scan, and a start pulse during a scan.

// File: rtl/rle_pkg.sv
package rle_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } rle_state_e;

    typedef struct packed {
        logic uniform;   // window fits and all its bits are equal
        logic head;      // value of the bit at the scan position
    } win_flags_t;

    function automatic int code_width(int n);
        return n * (2 + $clog2(n + 1));
    endfunction

endpackage

// File: rtl/rle_len_ctl.sv
module rle_len_ctl #(
    parameter int KMAX = 8,
    parameter int KW   = $clog2(KMAX + 1)
) (
    input  logic [KW-1:0] win_cfg,
    input  logic          uniform,
    output logic [KW-1:0] keff,
    output logic [KW-1:0] adv
);
    always_comb begin
        if (win_cfg == '0)
            keff = KW'(1);
        else if (int'(win_cfg) > KMAX)
            keff = KW'(KMAX);
        else
            keff = win_cfg;
        adv = uniform ? keff : KW'(1);
    end
endmodule

// File: rtl/rle_win_det.sv
module rle_win_det
    import rle_pkg::*;
#(
    parameter int N    = 64,
    parameter int KMAX = 8,
    parameter int KW   = $clog2(KMAX + 1),
    parameter int LW   = $clog2(N + 1)
) (
    input  logic [N-1:0]  data,
    input  logic [LW-1:0] pos,
    input  logic [KW-1:0] keff,
    output win_flags_t    flags
);
    logic [KMAX-1:0] win;
    logic            fits;
    logic            same;

    always_comb begin
        win  = KMAX'(data >> pos);
        fits = (int'(pos) + int'(keff)) <= N;
        same = 1'b1;
        for (int j = 1; j < KMAX; j++) begin
            if (j < int'(keff) && win[j] != win[0])
                same = 1'b0;
        end
        flags.head    = win[0];
        flags.uniform = fits && same;
    end
endmodule

// File: rtl/rle_tok_gen.sv
module rle_tok_gen #(
    parameter int N   = 64,
    parameter int LW  = $clog2(N + 1),
    parameter int TW  = ((2 * N) > (2 + LW)) ? (2 * N) : (2 + LW),
    parameter int TLW = $clog2(TW + 1)
) (
    input  logic           val,
    input  logic [LW-1:0]  len,
    input  logic [LW-1:0]  thresh,
    output logic [TW-1:0]  tok,
    output logic [TLW-1:0] tlen
);
    always_comb begin
        tok = '0;
        if (len > thresh) begin
            // run token: flag 1, value, length field LSB first
            tok  = TW'({len, val, 1'b1});
            tlen = TLW'(2 + LW);
        end else begin
            for (int i = 0; i < N; i++) begin
                tok[2*i]   = 1'b0;
                tok[2*i+1] = val && (i < int'(len));
            end
            tlen = TLW'(2 * int'(len));
        end
    end
endmodule

// File: rtl/rle_par_enc.sv
module rle_par_enc
    import rle_pkg::*;
#(
    parameter int N    = 64,
    parameter int KMAX = 8,
    localparam int LW  = $clog2(N + 1),
    localparam int KW  = $clog2(KMAX + 1),
    localparam int QW  = code_width(N),
    localparam int QLW = $clog2(QW + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [N-1:0]   data_i,
    input  logic [KW-1:0]  win_i,
    input  logic [LW-1:0]  thresh_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [QW-1:0]  code_o,
    output logic [QLW-1:0] code_len_o
);
    localparam int TW  = ((2 * N) > (2 + LW)) ? (2 * N) : (2 + LW);
    localparam int TLW = $clog2(TW + 1);

    rle_state_e     st_q;
    logic [N-1:0]   data_q;
    logic [KW-1:0]  win_q;
    logic [LW-1:0]  thr_q;
    logic [LW-1:0]  pos_q;
    logic           run_val_q;
    logic [LW-1:0]  run_len_q;
    logic [QW-1:0]  code_q;
    logic [QLW-1:0] len_q;

    win_flags_t     flags;
    logic [KW-1:0]  keff;
    logic [KW-1:0]  adv;
    logic [TW-1:0]  tok;
    logic [TLW-1:0] tlen;

    logic           extend;
    logic           emit;
    logic [LW-1:0]  pos_n;

    rle_win_det #(.N(N), .KMAX(KMAX), .KW(KW), .LW(LW)) i_det (
        .data  (data_q),
        .pos   (pos_q),
        .keff  (keff),
        .flags (flags)
    );

    rle_len_ctl #(.KMAX(KMAX), .KW(KW)) i_lctl (
        .win_cfg (win_q),
        .uniform (flags.uniform),
        .keff    (keff),
        .adv     (adv)
    );

    rle_tok_gen #(.N(N), .LW(LW), .TW(TW), .TLW(TLW)) i_tok (
        .val    (run_val_q),
        .len    (run_len_q),
        .thresh (thr_q),
        .tok    (tok),
        .tlen   (tlen)
    );

    always_comb begin
        extend = (run_len_q == '0) || (flags.head == run_val_q);
        emit   = ((st_q == ST_SCAN) && !extend) || (st_q == ST_FLUSH);
        pos_n  = pos_q + LW'(adv);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            data_q    <= '0;
            win_q     <= '0;
            thr_q     <= '0;
            pos_q     <= '0;
            run_val_q <= 1'b0;
            run_len_q <= '0;
            code_q    <= '0;
            len_q     <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_DONE: begin
                    if (start_i) begin
                        data_q    <= data_i;
                        win_q     <= win_i;
                        thr_q     <= thresh_i;
                        pos_q     <= '0;
                        run_val_q <= 1'b0;
                        run_len_q <= '0;
                        code_q    <= '0;
                        len_q     <= '0;
                        st_q      <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    pos_q     <= pos_n;
                    run_val_q <= flags.head;
                    if (extend)
                        run_len_q <= run_len_q + LW'(adv);
                    else
                        run_len_q <= LW'(adv);
                    if (int'(pos_n) >= N)
                        st_q <= ST_FLUSH;
                end
                ST_FLUSH: begin
                    st_q <= ST_DONE;
                end
                default: st_q <= ST_IDLE;
            endcase
            if (emit) begin
                code_q <= code_q | (QW'(tok) << len_q);
                len_q  <= len_q + QLW'(tlen);
            end
        end
    end

    assign busy_o     = (st_q == ST_SCAN) || (st_q == ST_FLUSH);
    assign done_o     = (st_q == ST_DONE);
    assign code_o     = code_q;
    assign code_len_o = len_q;
endmodule

// File: rtl/rle_par_enc_chk.sv
module rle_par_enc_chk #(
    parameter int N    = 64,
    parameter int KMAX = 8,
    localparam int LW  = $clog2(N + 1),
    localparam int KW  = $clog2(KMAX + 1),
    localparam int QW  = rle_pkg::code_width(N),
    localparam int QLW = $clog2(QW + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           start_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [QW-1:0]  code_o,
    input logic [QLW-1:0] code_len_o,
    input logic [LW-1:0]  pos,
    input logic [KW-1:0]  keff,
    input logic [KW-1:0]  adv
);
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(code_len_o) && $stable(code_o)));

    assert_len_grows_R6: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (code_len_o >= $past(code_len_o)));

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_o || done_o) |-> ((code_o >> code_len_o) == '0));

    assert_pos_bound_R3: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (int'(pos) <= N));

    assert_adv_choice_R2: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (adv == KW'(1) || adv == keff));

    assert_keff_range_R9: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (keff >= KW'(1) && int'(keff) <= KMAX));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ((busy_o || done_o) && code_len_o >= $past(code_len_o)));
endmodule

bind rle_par_enc rle_par_enc_chk #(.N(N), .KMAX(KMAX)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .code_o     (code_o),
    .code_len_o (code_len_o),
    .pos        (pos_q),
    .keff       (keff),
    .adv        (adv)
);

// File: tb/test_rle_par_enc.sv
module test_rle_par_enc;
    localparam int N    = 64;
    localparam int KMAX = 8;
    localparam int LW   = $clog2(N + 1);
    localparam int KW   = $clog2(KMAX + 1);
    localparam int QW   = N * (2 + LW);
    localparam int QLW  = $clog2(QW + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start_i = 1'b0;
    logic [N-1:0]   data_i = '0;
    logic [KW-1:0]  win_i = '0;
    logic [LW-1:0]  thresh_i = '0;
    logic           busy_o;
    logic           done_o;
    logic [QW-1:0]  code_o;
    logic [QLW-1:0] code_len_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    rle_par_enc #(.N(N), .KMAX(KMAX)) i_rle_par_enc (
        .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i),
        .win_i(win_i), .thresh_i(thresh_i), .busy_o(busy_o),
        .done_o(done_o), .code_o(code_o), .code_len_o(code_len_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: scan step count and expected token stream
    task automatic model(input logic [N-1:0] d, input int k, input int m,
                         output int steps, output logic [QW-1:0] ecode, output int elen);
        int ke = (k == 0) ? 1 : ((k > KMAX) ? KMAX : k);
        int pos = 0;
        int i = 0;
        bit q[$];
        steps = 0;
        while (pos < N) begin
            bit u = 0;
            if (pos + ke <= N) begin
                u = 1;
                for (int j = 1; j < ke; j++) if (d[pos+j] != d[pos]) u = 0;
            end
            pos += u ? ke : 1;
            steps++;
        end
        while (i < N) begin
            bit b = d[i];
            int len = 0;
            while (i < N && d[i] == b) begin len++; i++; end
            if (len > m) begin
                q.push_back(1'b1); q.push_back(b);
                for (int j = 0; j < LW; j++) q.push_back(len[j]);
            end else begin
                for (int j = 0; j < len; j++) begin q.push_back(1'b0); q.push_back(b); end
            end
        end
        ecode = '0;
        elen = q.size();
        for (int j = 0; j < elen; j++) ecode[j] = q[j];
    endtask

    task automatic run_case(input string name, input logic [N-1:0] d, input int k,
                            input int m, input bit disturb, input bit restart);
        int steps, elen, p, bi;
        logic [QW-1:0] ecode;
        logic [N-1:0] dec;
        bit ok;
        model(d, k, m, steps, ecode, elen);
        data_i = d; win_i = KW'(k); thresh_i = LW'(m); start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        for (int e = 1; e <= steps + 2; e++) begin
            if (e > 1) begin @(posedge clk); @(negedge clk); end
            if (disturb && e == 1) begin
                data_i = ~d; win_i = KW'(3); thresh_i = LW'(1);   // R10: ignored
            end
            if (restart && e == 2) begin start_i = 1'b1; data_i = ~d; end  // R11
            if (restart && e == 3) start_i = 1'b0;
            // R2 R3 R7: cycle timing follows the window-skip step count
            chk(busy_o == (e <= steps + 1), "R7", {name, " busy"}, busy_o, e <= steps + 1);
            chk(done_o == (e >= steps + 2), "R2", {name, " done timing"}, done_o, e >= steps + 2);
        end
        chk(int'(code_len_o) == elen, "R6", {name, " code length"}, code_len_o, elen);
        checks++;
        if (code_o !== ecode) begin   // R4 R5 R6 R10 R11
            errors++;
            $display("FAIL R4/R5 %s code: actual=%h expected=%h", name, code_o, ecode);
        end
        // R8: decode the produced stream
        dec = '0; p = 0; bi = 0; ok = 1;
        while (p < int'(code_len_o) && ok) begin
            if (code_o[p]) begin
                int len = 0;
                for (int j = 0; j < LW; j++) len |= int'(code_o[p+2+j]) << j;
                for (int j = 0; j < len; j++) begin
                    if (bi < N) dec[bi] = code_o[p+1]; else ok = 0;
                    bi++;
                end
                p += 2 + LW;
            end else begin
                if (bi < N) dec[bi] = code_o[p+1]; else ok = 0;
                bi++;
                p += 2;
            end
        end
        chk(ok && bi == N && dec == d, "R8", {name, " decoded bit count"}, bi, N);
        @(posedge clk); @(negedge clk);
        chk(done_o && int'(code_len_o) == elen, "R7", {name, " hold"}, code_len_o, elen);
    endtask

    function automatic logic [N-1:0] runny(input int flip_odds);
        logic [N-1:0] v = '0;
        bit b = bit'($urandom_range(0, 1));
        for (int i = 0; i < N; i++) begin
            if ($urandom_range(0, flip_odds - 1) == 0) b = ~b;
            v[i] = b;
        end
        return v;
    endfunction

    initial begin
        void'($urandom(1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(!busy_o && !done_o && code_len_o == 0 && code_o == '0, "R1", "reset state",
            {busy_o, done_o}, 0);
        run_case("zeros k8 m4", '0, 8, 4, 0, 0);
        run_case("ones k4 m4", '1, 4, 4, 0, 0);
        run_case("zeros tail k5", '0, 5, 10, 0, 0);               // R3
        run_case("alternating k8 m2", {(N/2){2'b01}}, 8, 2, 0, 0); // R3 R5
        run_case("zeros m=N literal", '0, 8, N, 0, 0);            // R5
        run_case("zeros m=N-1 run", '0, 8, N - 1, 0, 0);          // R4
        run_case("run at threshold", 64'h1F, 2, 5, 0, 0);         // R5
        run_case("run above threshold", 64'h1F, 2, 4, 0, 0);      // R4
        run_case("win zero", 64'hFF00_0F0F_0000_FFFF, 0, 3, 0, 0); // R9
        run_case("win clamp", 64'hFF00_0F0F_0000_FFFF, 15, 3, 0, 0); // R9
        run_case("inputs change busy", 64'h0000_FFFF_00F0_0001, 4, 3, 1, 0); // R10
        run_case("start while busy", '1, 2, 2, 0, 1);            // R11
        for (int t = 0; t < 12; t++) begin
            int k = 1 + (t % KMAX);
            int m = t % 7;
            run_case("random runs", runny(2 + (t % 9)), k, m, 0, 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule